// File: doc/BRIEF.md
# Microcoded Protocol Sequencer

This block is a small microcoded controller. It walks a byte-wide program image that is fixed at elaboration time and turns it into a series of control strobes for a network protocol engine. A free-running clock divider generates two enables. The faster enable advances the program counter. The slower one, at half that rate, executes an instruction.

Each instruction is two bytes: an opcode byte and then an immediate byte. Both are fetched before the instruction executes. The opcode's top two bits select one of four classes:

- timed wait
- jump
- strobe
- restart of the watchdog-style reconfiguration timer

The reconfiguration timer counts execute slots. If it reaches its limit, it preempts the program: the program counter returns to zero and, one clock later, a sticky status bit rises. That bit clears only through an external clear strobe.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `stb_o` is 0, `hold_o` is 0 and `recon_o` is 0.
- R2: A phase counter cycles 0..7 (with PC_DIV=4). On the clock at phase 3 the opcode byte is latched from `pc_o` and `pc_o` increments. On the clock at phase 7 the immediate byte is latched the same way. Phase 0 is the execute slot. Fetches are skipped while a wait is pending.
- R3: An opcode whose bits [7:6] are 2'b10 is a strobe. In its execute slot it drives `stb_o` with immediate bits [NSTB-1:0] for exactly one clock; otherwise `stb_o` is 0.
- R4: An increment from the last image address (ROM_DEPTH-1) gives address 0.
- R5: An opcode with bits [7:6] = 2'b00 is a timed wait. It loads a count of immediate × NOP_UNIT execute slots, and `hold_o` is high while the count is nonzero. Each later execute slot decrements the count instead of executing, and `pc_o` stays frozen throughout.
- R6: An opcode with bits [7:6] = 2'b01 is a jump to {opcode[PC_W-9:0], immediate}. A target at or above ROM_DEPTH loads address 0.
- R7: An opcode with bits [7:6] = 2'b11 clears the reconfiguration timer. A program that executes it more often than every RECON_TICKS execute slots never raises `recon_o`.
- R8: The timer counts every execute slot. In the slot where it reaches RECON_TICKS, it:
  - sets `pc_o` to 0,
  - cancels any pending wait,
  - discards that slot's instruction,
  - restarts its own count.
- R9: `recon_o` rises one clock after an expiry and then stays high. A one-clock high on `recon_clr` clears it, but a set arriving on the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recon_clr | input | 1 | Clears the reconfiguration status bit |
| pc_o | output | PC_W | Current program counter |
| stb_o | output | NSTB | One-clock control strobe vector |
| hold_o | output | 1 | A timed wait is in progress |
| recon_o | output | 1 | Sticky reconfiguration status |

## Verification
The hardest situation to reach from the ports is a timer expiry, since it needs a program that never restarts the timer. A second instance therefore runs a different image: a jump loop that also crosses the end of the image, so it covers both wraparound and repeated expiry. On that instance the clear input is held high across a later expiry edge to test that a set beats a clear. A behavioural model in the bench tracks both instances clock by clock.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int ROM_DEPTH = 554,
  parameter int PC_W = 10,
  parameter int NSTB = 8,
  parameter int PC_DIV = 4,
  parameter int NOP_UNIT = 4,
  parameter int RECON_TICKS = 2048,
  parameter logic [ROM_DEPTH*8-1:0] ROM_IMG = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            recon_clr,
  output logic [PC_W-1:0] pc_o,
  output logic [NSTB-1:0] stb_o,
  output logic            hold_o,
  output logic            recon_o
);
  localparam int EXE_DIV = 2 * PC_DIV;
  localparam int DIV_W = $clog2(EXE_DIV);
  localparam int WAIT_W = 8 + $clog2(NOP_UNIT + 1);
  localparam int RT_W = $clog2(RECON_TICKS);
  localparam logic [WAIT_W-1:0] UNIT = WAIT_W'(NOP_UNIT);

  logic [7:0] rom [ROM_DEPTH];
  for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_rom
    assign rom[gi] = ROM_IMG[gi*8 +: 8];
  end

  logic [DIV_W-1:0]  div_q;
  logic [PC_W-1:0]   pc_q;
  logic [7:0]        op_q, imm_q;
  logic [WAIT_W-1:0] wait_q;
  logic [RT_W-1:0]   rt_q;
  logic [NSTB-1:0]   stb_q;
  logic              pend_q, flag_q;

  wire        busy      = wait_q != '0;
  wire        tick      = div_q == '0;
  wire        fetch_op  = (div_q == DIV_W'(PC_DIV - 1)) && !busy;
  wire        fetch_imm = (div_q == DIV_W'(EXE_DIV - 1)) && !busy;
  wire        expire    = tick && (rt_q == RT_W'(RECON_TICKS - 1));
  wire        run       = tick && !expire && !busy;
  wire [1:0]  cls       = op_q[7:6];
  wire [7:0]  rom_q     = rom[pc_q];
  wire [PC_W-1:0] pc_inc  = (pc_q == PC_W'(ROM_DEPTH - 1)) ? '0 : pc_q + 1'b1;
  wire [PC_W-1:0] jmp_tgt = {op_q[PC_W-9:0], imm_q};
  wire [PC_W-1:0] jmp_pc  = (jmp_tgt < PC_W'(ROM_DEPTH)) ? jmp_tgt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pc_q   <= '0;
      op_q   <= '0;
      imm_q  <= '0;
      wait_q <= '0;
      rt_q   <= '0;
      stb_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      div_q <= (div_q == DIV_W'(EXE_DIV - 1)) ? '0 : div_q + 1'b1;

      if (fetch_op) op_q <= rom_q;
      if (fetch_imm) imm_q <= rom_q;

      if (expire) pc_q <= '0;
      else if (run && cls == 2'b01) pc_q <= jmp_pc;
      else if (fetch_op || fetch_imm) pc_q <= pc_inc;

      if (expire) wait_q <= '0;
      else if (tick && busy) wait_q <= wait_q - 1'b1;
      else if (run && cls == 2'b00) wait_q <= WAIT_W'(imm_q) * UNIT;

      if (tick) rt_q <= (expire || (run && cls == 2'b11)) ? '0 : rt_q + 1'b1;

      stb_q  <= (run && cls == 2'b10) ? imm_q[NSTB-1:0] : '0;
      pend_q <= expire;
      flag_q <= pend_q | (flag_q & ~recon_clr);
    end
  end

  assign pc_o    = pc_q;
  assign stb_o   = stb_q;
  assign hold_o  = busy;
  assign recon_o = flag_q;
endmodule

module ucode_seq_chk #(
  parameter int ROM_DEPTH = 554,
  parameter int PC_W = 10,
  parameter int NSTB = 8,
  parameter int DIV_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            recon_clr,
  input logic [PC_W-1:0] pc_o,
  input logic [NSTB-1:0] stb_o,
  input logic            hold_o,
  input logic            recon_o,
  input logic [DIV_W-1:0] div_q
);
  AST_PC_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n) pc_o < PC_W'(ROM_DEPTH)); // R4
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + 1'b1 || pc_o == '0 || $past(div_q) == '0)); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (stb_o != '0) |=> (stb_o == '0)); // R3
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> (pc_o == $past(pc_o) || pc_o == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_o && !recon_clr) |=> recon_o); // R9
endmodule

bind ucode_seq ucode_seq_chk #(
  .ROM_DEPTH(ROM_DEPTH), .PC_W(PC_W), .NSTB(NSTB), .DIV_W(DIV_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .recon_clr(recon_clr), .pc_o(pc_o), .stb_o(stb_o),
  .hold_o(hold_o), .recon_o(recon_o), .div_q(div_q)
);

// File: tb/ucode_seq_tb.sv
module ucode_seq_ref #(
  parameter int DEPTH = 40,
  parameter int NS = 4,
  parameter int UNIT = 2,
  parameter int RT = 60,
  parameter logic [DEPTH*8-1:0] IMG = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output int   e_pc,
  output int   e_stb,
  output int   e_hold,
  output int   e_flag
);
  int phase, pc, op, imm, waitv, tmr, pend, flag, stb;
  function automatic int rb(int a);
    return int'(IMG[a*8 +: 8]);
  endfunction
  function automatic int nxt(int a);
    return (a + 1 >= DEPTH) ? 0 : a + 1;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; pc = 0; op = 0; imm = 0; waitv = 0; tmr = 0; pend = 0; flag = 0; stb = 0;
    end else begin
      int ph, t;
      ph = phase;
      phase = (phase + 1) % 8;
      stb = 0;
      flag = pend ? 1 : (clr ? 0 : flag);
      pend = 0;
      if (ph == 3 && waitv == 0) begin op = rb(pc); pc = nxt(pc); end
      else if (ph == 7 && waitv == 0) begin imm = rb(pc); pc = nxt(pc); end
      else if (ph == 0) begin
        if (tmr == RT - 1) begin
          pc = 0; waitv = 0; tmr = 0; pend = 1;
        end else begin
          tmr++;
          if (waitv > 0) waitv--;
          else begin
            case (op / 64)
              0: waitv = imm * UNIT;
              1: begin t = (op % 4) * 256 + imm; pc = (t < DEPTH) ? t : 0; end
              2: stb = imm % (1 << NS);
              default: tmr = 0;
            endcase
          end
        end
      end
    end
    e_pc = pc; e_stb = stb; e_hold = (waitv != 0); e_flag = flag;
  end
endmodule

module ucode_seq_tb_top;
  localparam int DEPTH = 40;
  localparam int PCW = 10;
  localparam int NS = 4;
  localparam int UNIT = 2;
  localparam int RT = 60;

  function automatic logic [DEPTH*8-1:0] put(logic [DEPTH*8-1:0] r, int a, int op, int imm);
    r[a*8 +: 8] = 8'(op);
    r[(a+1)*8 +: 8] = 8'(imm);
    return r;
  endfunction

  function automatic logic [DEPTH*8-1:0] mk_rom(int sel);
    logic [DEPTH*8-1:0] r;
    r = '0;
    if (sel == 0) begin
      r = put(r, 0, 8'h80, 8'h05);
      r = put(r, 2, 8'h00, 8'h03);
      r = put(r, 4, 8'h80, 8'h0A);
      r = put(r, 6, 8'hC0, 8'h00);
      r = put(r, 8, 8'h40, 8'h0C);
      r = put(r, 10, 8'h80, 8'h0F);
      r = put(r, 12, 8'h00, 8'h00);
      r = put(r, 14, 8'h80, 8'h03);
      r = put(r, 16, 8'h40, 8'h1E);
      r = put(r, 30, 8'h80, 8'h01);
      r = put(r, 32, 8'h00, 8'h01);
      r = put(r, 34, 8'h43, 8'hF0);
    end else begin
      r = put(r, 0, 8'h80, 8'h01);
      r = put(r, 2, 8'h40, 8'h24);
      r = put(r, 36, 8'h80, 8'h02);
      r = put(r, 38, 8'h80, 8'h04);
    end
    return r;
  endfunction

  localparam logic [DEPTH*8-1:0] ROM_A = mk_rom(0);
  localparam logic [DEPTH*8-1:0] ROM_B = mk_rom(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_a = 1'b0;
  logic clr_b = 1'b0;
  logic run = 1'b0;
  logic done = 1'b0;
  always #4 clk = ~clk;

  logic [PCW-1:0] pc_a, pc_b;
  logic [NS-1:0]  stb_a, stb_b;
  logic hold_a, hold_b, flag_a, flag_b;
  int ea_pc, ea_stb, ea_hold, ea_flag, eb_pc, eb_stb, eb_hold, eb_flag;

  ucode_seq #(.ROM_DEPTH(DEPTH), .PC_W(PCW), .NSTB(NS), .PC_DIV(4), .NOP_UNIT(UNIT),
              .RECON_TICKS(RT), .ROM_IMG(ROM_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .recon_clr(clr_a), .pc_o(pc_a), .stb_o(stb_a),
    .hold_o(hold_a), .recon_o(flag_a));

  ucode_seq #(.ROM_DEPTH(DEPTH), .PC_W(PCW), .NSTB(NS), .PC_DIV(4), .NOP_UNIT(UNIT),
              .RECON_TICKS(RT), .ROM_IMG(ROM_B)) dut_x (
    .clk(clk), .rst_n(rst_n), .recon_clr(clr_b), .pc_o(pc_b), .stb_o(stb_b),
    .hold_o(hold_b), .recon_o(flag_b));

  ucode_seq_ref #(.DEPTH(DEPTH), .NS(NS), .UNIT(UNIT), .RT(RT), .IMG(ROM_A)) ref_a (
    .clk(clk), .rst_n(rst_n), .clr(clr_a), .e_pc(ea_pc), .e_stb(ea_stb), .e_hold(ea_hold), .e_flag(ea_flag));
  ucode_seq_ref #(.DEPTH(DEPTH), .NS(NS), .UNIT(UNIT), .RT(RT), .IMG(ROM_B)) ref_b (
    .clk(clk), .rst_n(rst_n), .clr(clr_b), .e_pc(eb_pc), .e_stb(eb_stb), .e_hold(eb_hold), .e_flag(eb_flag));

  int checks = 0;
  int errors = 0;
  int wraps_b = 0, holds_a = 0, jumps_a = 0, flag_a_seen = 0, prev_pc_b = 0, prev_pc_a = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("R2 R4 R5 R6 R8", "pc A", int'(pc_a), ea_pc);
      chk("R3", "strobe A", int'(stb_a), ea_stb);
      chk("R5", "hold A", int'(hold_a), ea_hold);
      chk("R7 R9", "flag A", int'(flag_a), ea_flag);
      chk("R2 R4 R8", "pc B", int'(pc_b), eb_pc);
      chk("R3", "strobe B", int'(stb_b), eb_stb);
      chk("R5", "hold B", int'(hold_b), eb_hold);
      chk("R8 R9", "flag B", int'(flag_b), eb_flag);
      if (prev_pc_b == DEPTH - 1 && pc_b == '0) wraps_b++;
      if (prev_pc_a == 10 && pc_a == 12) jumps_a++;
      if (hold_a) holds_a++;
      if (flag_a) flag_a_seen = 1;
      prev_pc_b = int'(pc_b);
      prev_pc_a = int'(pc_a);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", int'(pc_a), 0);
    chk("R1", "reset strobe", int'(stb_b), 0);
    chk("R1", "reset hold", int'(hold_a), 0);
    chk("R1", "reset flag", int'(flag_b), 0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (520) @(negedge clk);
    chk("R8", "flag B after first expiry", int'(flag_b), 1);
    clr_b = 1'b1;
    @(negedge clk);
    clr_b = 1'b0;
    @(negedge clk);
    chk("R9", "flag B after clear", int'(flag_b), 0);
    repeat (420) @(negedge clk);
    clr_b = 1'b1;
    repeat (40) @(negedge clk);
    clr_b = 1'b0;
    repeat (500) @(negedge clk);
    chk("R4", "wraps seen on B", int'(wraps_b > 0), 1);
    chk("R5", "wait cycles seen on A", int'(holds_a > 0), 1);
    chk("R6", "jump 10->12 seen on A", int'(jumps_a > 0), 1);
    chk("R7", "flag A never set", flag_a_seen, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule